// File: doc/BRIEF.md
# Fully Associative LRU Tag Store with Capacity Profiling

This block holds the tags of a cache with a single set, in which every entry may hold any block. The tag of an entry is the block-aligned address: the address with its block-offset bits dropped. The entries are kept in recency order. Each entry carries an age rank, from 0 for the most recently used entry up to `N_ENTRIES-1` for the least recently used one. A lookup reports in the same cycle whether it hit and which entry it hit. On the next clock edge the hit entry becomes the most recently used one. The least recently used entry is always presented as the replacement victim. Insert fills that victim. Invalidate drops an entry and sends it to the old end of the order.

The block also profiles capacity. The tracked capacities are `MIN_CAP`, `2*MIN_CAP`, and so on below `N_ENTRIES`, so there are log2(`N_ENTRIES`) - log2(`MIN_CAP`) of them. A smaller LRU cache of capacity C would hold exactly the entries whose rank is below C. From this, every lookup yields a fit mask of which smaller caches would also have hit. Per-capacity hit and miss counters and a total lookup counter turn this into miss curves for a whole ladder of sizes from one run.

Top module: `falru_tag_store`

## Requirements
- R1: After reset all entries are invalid and ranks equal entry indices. The victim is entry `N_ENTRIES-1`, every lookup misses and all counters read zero.
- R2: `hit_o` is high during a lookup exactly when a valid entry's tag equals `lookup_addr_i[ADDR_W-1:OFS_W]`. The low `OFS_W` address bits are ignored, and `hit_idx_o` gives that entry's index.
- R3: On a lookup hit, the hit entry takes rank 0. Entries that were younger than it age by one and the other entries keep their rank.
- R4: `victim_idx_o` always names the single entry of rank `N_ENTRIES-1`.
- R5: Insert writes the tag of `insert_addr_i` into the current victim, sets it valid and promotes it to rank 0 as in R3.
- R6: Invalidate clears the valid bit of entry `inval_idx_i` and moves it to rank `N_ENTRIES-1`. Entries that were older than it move one rank younger. Invalidate is ignored in a cycle where `lookup_i` or `insert_i` is high.
- R7: Bit b of `fit_mask_o` stands for capacity `MIN_CAP<<b` (bit 0 is the smallest). The bit is 1 exactly when the lookup hits an entry whose rank is below `MIN_CAP<<b`. The mask is all zero on a miss.
- R8: Each lookup increments `accesses_o` by one. For every capacity b, a lookup increments field b of `size_hits_o` when bit b of the fit mask is 1, and increments field b of `size_misses_o` otherwise, so a full-store miss counts as a miss for every capacity. Field b occupies bits `[b*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_i | input | 1 | Lookup request this cycle |
| lookup_addr_i | input | ADDR_W | Lookup address |
| hit_o | output | 1 | Lookup hit (combinational) |
| hit_idx_o | output | IDX_W | Entry index of the hit |
| fit_mask_o | output | N_SIZES | Capacities that would also hit |
| insert_i | input | 1 | Fill the victim entry |
| insert_addr_i | input | ADDR_W | Address to fill |
| invalidate_i | input | 1 | Invalidate an entry |
| inval_idx_i | input | IDX_W | Entry to invalidate |
| victim_idx_o | output | IDX_W | Current LRU entry |
| size_hits_o | output | N_SIZES*CNT_W | Per-capacity hit counters |
| size_misses_o | output | N_SIZES*CNT_W | Per-capacity miss counters |
| accesses_o | output | CNT_W | Total lookups |

## Verification
Several rules are checked on every cycle:
- the victim entry is unique;
- a hit matches only one entry;
- the fit mask has thermometer form and is empty on a miss;
- hit and insert leave the touched entry at rank 0, and invalidate leaves it as the victim;
- each lookup steps the access counter by one.

Three things come only from the bench's scenarios: the exact aging of the other entries, the fit mask values for each rank, and the per-capacity counter totals. The bench compares these with a rank model over forward, reverse and strided lookup sweeps, repeated hits, misses, and an invalidate that collides with a lookup.

// File: rtl/falru_pkg.sv
package falru_pkg;
  // capacity in blocks represented by fit-mask bit b
  function automatic int unsigned cap_of(int unsigned min_cap, int unsigned b);
    return min_cap << b;
  endfunction
endpackage

// File: rtl/falru_rank.sv
module falru_rank #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             promote_i,
  input  logic             demote_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] rank_o [N_ENTRIES],
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] rank_q [N_ENTRIES];
  logic [IDX_W-1:0] sel_rank;
  logic [N_ENTRIES-1:0] last_vec;

  assign sel_rank = rank_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (promote_i) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (IDX_W'(i) == idx_i)        rank_q[i] <= '0;
        else if (rank_q[i] < sel_rank) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end else if (demote_i) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (IDX_W'(i) == idx_i)        rank_q[i] <= LAST;
        else if (rank_q[i] > sel_rank) rank_q[i] <= rank_q[i] - 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      last_vec[i] = (rank_q[i] == LAST);
      if (last_vec[i]) victim_o = IDX_W'(i);
    end
  end

  assign rank_o = rank_q;

  // R4
  victim_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(last_vec) == 1);
endmodule

// File: rtl/falru_match.sv
module falru_match #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned TAG_W     = 12,
  parameter int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] tags_i  [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] valid_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) if (match[i]) idx_o = IDX_W'(i);
  end

  assign any_o = |match;

  // R2
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> $onehot(match));
endmodule

// File: rtl/falru_stats.sv
module falru_stats #(
  parameter int unsigned N_SIZES = 2,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lookup_i,
  input  logic [N_SIZES-1:0]       fit_i,
  output logic [N_SIZES*CNT_W-1:0] hits_o,
  output logic [N_SIZES*CNT_W-1:0] misses_o,
  output logic [CNT_W-1:0]         acc_o
);
  logic [CNT_W-1:0] acc_q;

  for (genvar b = 0; b < N_SIZES; b++) begin : g_size
    logic [CNT_W-1:0] hit_q, mis_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q <= '0;
        mis_q <= '0;
      end else if (lookup_i) begin
        if (fit_i[b]) hit_q <= hit_q + 1'b1;
        else          mis_q <= mis_q + 1'b1;
      end
    end
    assign hits_o[b*CNT_W +: CNT_W]   = hit_q;
    assign misses_o[b*CNT_W +: CNT_W] = mis_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (lookup_i) acc_q <= acc_q + 1'b1;
  end
  assign acc_o = acc_q;

  // R8
  acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> acc_q == $past(acc_q) + 1'b1);
endmodule

// File: rtl/falru_tag_store.sv
module falru_tag_store
  import falru_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFS_W     = 4,
  parameter int unsigned MIN_CAP   = 2,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned N_SIZES  = $clog2(N_ENTRIES) - $clog2(MIN_CAP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lookup_i,
  input  logic [ADDR_W-1:0]        lookup_addr_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         hit_idx_o,
  output logic [N_SIZES-1:0]       fit_mask_o,
  input  logic                     insert_i,
  input  logic [ADDR_W-1:0]        insert_addr_i,
  input  logic                     invalidate_i,
  input  logic [IDX_W-1:0]         inval_idx_i,
  output logic [IDX_W-1:0]         victim_idx_o,
  output logic [N_SIZES*CNT_W-1:0] size_hits_o,
  output logic [N_SIZES*CNT_W-1:0] size_misses_o,
  output logic [CNT_W-1:0]         accesses_o
);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0]     tag_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]     rank_w [N_ENTRIES];
  logic                 any_match;
  logic [IDX_W-1:0]     match_idx, upd_idx, hit_rank;
  logic                 do_hit, do_inv, promote;
  logic [N_SIZES-1:0]   fit_inc;

  falru_match #(.N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) match_i (
    .clk_i, .rst_ni,
    .tag_i   (lookup_addr_i[ADDR_W-1:OFS_W]),
    .tags_i  (tag_q),
    .valid_i (valid_q),
    .any_o   (any_match),
    .idx_o   (match_idx)
  );

  assign hit_o     = lookup_i && any_match;
  assign hit_idx_o = match_idx;
  assign hit_rank  = rank_w[match_idx];

  for (genvar b = 0; b < N_SIZES; b++) begin : g_fit
    assign fit_mask_o[b] = hit_o && (hit_rank < IDX_W'(cap_of(MIN_CAP, b)));
  end

  // insert wins over lookup; invalidate only in an otherwise idle cycle
  assign do_hit  = hit_o && !insert_i;
  assign do_inv  = invalidate_i && !lookup_i && !insert_i;
  assign promote = insert_i || do_hit;
  assign upd_idx = insert_i ? victim_idx_o : (do_hit ? match_idx : inval_idx_i);

  falru_rank #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) rank_i (
    .clk_i, .rst_ni,
    .promote_i (promote),
    .demote_i  (do_inv),
    .idx_i     (upd_idx),
    .rank_o    (rank_w),
    .victim_o  (victim_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N_ENTRIES; i++) tag_q[i] <= '0;
    end else if (insert_i) begin
      valid_q[victim_idx_o] <= 1'b1;
      tag_q[victim_idx_o]   <= insert_addr_i[ADDR_W-1:OFS_W];
    end else if (do_inv) begin
      valid_q[inval_idx_i] <= 1'b0;
    end
  end

  falru_stats #(.N_SIZES(N_SIZES), .CNT_W(CNT_W)) stats_i (
    .clk_i, .rst_ni,
    .lookup_i (lookup_i),
    .fit_i    (fit_mask_o),
    .hits_o   (size_hits_o),
    .misses_o (size_misses_o),
    .acc_o    (accesses_o)
  );

  assign fit_inc = ~fit_mask_o + 1'b1;

  // R3
  hit_to_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && hit_o && !insert_i) |=> rank_w[$past(hit_idx_o)] == '0);
  // R5
  insert_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_i |=> valid_q[$past(victim_idx_o)] && rank_w[$past(victim_idx_o)] == '0);
  // R6
  inval_to_lru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalidate_i && !lookup_i && !insert_i) |=>
      victim_idx_o == $past(inval_idx_i) && !valid_q[$past(inval_idx_i)]);
  // R7
  fit_thermo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fit_inc));
  // R7
  fit_miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> fit_mask_o == '0);
endmodule

// File: tb/falru_tag_store_tb.sv
`timescale 1ns/1ps
module falru_tag_store_tb_top;
  localparam int N = 8, AW = 16, OW = 4, MINC = 2, CW = 16, IW = 3, NS = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic lookup_i = 0, insert_i = 0, invalidate_i = 0;
  logic [AW-1:0] lookup_addr_i = '0, insert_addr_i = '0;
  logic [IW-1:0] inval_idx_i = '0;
  logic hit_o;
  logic [IW-1:0] hit_idx_o, victim_idx_o;
  logic [NS-1:0] fit_mask_o;
  logic [NS*CW-1:0] size_hits_o, size_misses_o;
  logic [CW-1:0] accesses_o;

  always #2.5 clk_i = ~clk_i;

  falru_tag_store #(.N_ENTRIES(N), .ADDR_W(AW), .OFS_W(OW), .MIN_CAP(MINC), .CNT_W(CW)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int r_rank[N], r_tag[N];
  bit r_val[N];
  int m_hit[NS], m_mis[NS], m_acc;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_victim();
    for (int i = 0; i < N; i++) if (r_rank[i] == N - 1) return i;
    return -1;
  endfunction

  function automatic int find(int tag);
    for (int i = 0; i < N; i++) if (r_val[i] && r_tag[i] == tag) return i;
    return -1;
  endfunction

  task automatic m_promote(int p);
    int rp = r_rank[p];
    for (int i = 0; i < N; i++)
      if (i == p) r_rank[i] = 0;
      else if (r_rank[i] < rp) r_rank[i]++;
  endtask

  task automatic m_demote(int p);
    int rp = r_rank[p];
    for (int i = 0; i < N; i++)
      if (i == p) r_rank[i] = N - 1;
      else if (r_rank[i] > rp) r_rank[i]--;
  endtask

  task automatic m_lookup(int e);
    m_acc++;
    for (int b = 0; b < NS; b++)
      if (e >= 0 && r_rank[e] < (MINC << b)) m_hit[b]++; else m_mis[b]++;
    if (e >= 0) m_promote(e);
  endtask

  task automatic op_lookup(logic [AW-1:0] addr, string mreq);
    int e, m;
    @(negedge clk_i);
    lookup_i = 1; lookup_addr_i = addr;
    #1;
    chk("R4 victim", victim_idx_o, exp_victim());
    e = find(addr >> OW);
    chk("R2 hit", hit_o, e >= 0);
    if (e >= 0) chk("R2 index", hit_idx_o, e);
    m = 0;
    for (int b = 0; b < NS; b++) if (e >= 0 && r_rank[e] < (MINC << b)) m |= 1 << b;
    chk(mreq, fit_mask_o, m);
    @(posedge clk_i); #1;
    lookup_i = 0;
    m_lookup(e);
  endtask

  task automatic op_insert(logic [AW-1:0] addr);
    int v;
    @(negedge clk_i);
    insert_i = 1; insert_addr_i = addr;
    #1;
    v = exp_victim();
    chk("R4 victim before insert", victim_idx_o, v);
    @(posedge clk_i); #1;
    insert_i = 0;
    r_tag[v] = addr >> OW; r_val[v] = 1; m_promote(v);
  endtask

  task automatic op_inval(int idx);
    @(negedge clk_i);
    invalidate_i = 1; inval_idx_i = IW'(idx);
    @(posedge clk_i); #1;
    invalidate_i = 0;
    r_val[idx] = 0; m_demote(idx);
  endtask

  task automatic chk_counters(string req);
    @(negedge clk_i);
    chk({req, " accesses"}, accesses_o, m_acc);
    for (int b = 0; b < NS; b++) begin
      chk({req, " size hits"}, size_hits_o[b*CW +: CW], m_hit[b]);
      chk({req, " size misses"}, size_misses_o[b*CW +: CW], m_mis[b]);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(int k, int ofs);
    return AW'(((16 + 3 * k) << OW) | (ofs & 15));
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int x, y;
    for (int i = 0; i < N; i++) begin r_rank[i] = i; r_val[i] = 0; r_tag[i] = 0; end
    for (int b = 0; b < NS; b++) begin m_hit[b] = 0; m_mis[b] = 0; end
    m_acc = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset victim", victim_idx_o, N - 1);
    chk("R1 reset accesses", accesses_o, 0);
    chk("R1 reset hits", size_hits_o, 0);
    chk("R1 reset misses", size_misses_o, 0);
    @(negedge clk_i) rst_ni = 1;
    op_lookup(16'h0000, "R1 empty lookup mask");
    op_lookup(addr_of(0, 0), "R1 empty lookup mask");
    for (int k = 0; k < N; k++) op_insert(addr_of(k, k));
    chk("R5 victim after fills", victim_idx_o, exp_victim());
    for (int k = 0; k < N; k++) op_lookup(addr_of(k, 15 - k), "R7 forward");
    for (int k = N - 1; k >= 0; k--) op_lookup(addr_of(k, k * 5), "R7 reverse");
    for (int j = 0; j < 2 * N; j++) op_lookup(addr_of((3 * j) % N, j), "R7 stride");
    op_lookup(addr_of(4, 0), "R7 single");
    op_lookup(addr_of(4, 9), "R3 repeat hit is MRU");
    for (int k = 0; k < 3; k++) op_lookup(addr_of(20 + k, 0), "R2 miss mask");
    chk_counters("R8");
    x = find(addr_of(2, 0) >> OW);
    op_inval(x);
    @(negedge clk_i);
    chk("R6 invalidated is victim", victim_idx_o, x);
    op_lookup(addr_of(2, 0), "R6 invalidated misses");
    y = find(addr_of(6, 0) >> OW);
    @(negedge clk_i);
    invalidate_i = 1; inval_idx_i = IW'(y);
    lookup_i = 1; lookup_addr_i = addr_of(5, 0);
    @(posedge clk_i); #1;
    invalidate_i = 0; lookup_i = 0;
    m_lookup(find(addr_of(5, 0) >> OW));
    @(negedge clk_i);
    chk("R6 ignored with lookup victim", victim_idx_o, exp_victim());
    op_lookup(addr_of(6, 3), "R6 ignored entry still hits");
    op_insert(addr_of(30, 0));
    op_lookup(addr_of(30, 7), "R5 inserted is MRU");
    for (int k = 0; k < N; k++) op_lookup(addr_of(k, 1), "R7 final sweep");
    chk_counters("R8 final");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule